// File: doc/BRIEF.md
# Fractional-N divider ratio sequencer

This block supplies the integer feedback division value of a fractional-N frequency synthesizer, one value per enabled reference-rate cycle. Each value is either the programmed integer part or that part plus one. The choice is made so that the long-run mean ratio equals INT + FRAC/MOD. A fractional accumulator of modulus MOD gains FRAC on every enabled cycle. When it wraps, it raises a carry and that cycle's value becomes INT+1.

The programmed words are INT (16 bits), FRAC, MOD and PHASE (12 bits each), a prescaler-mode bit and a dither enable. They take effect only on a load strobe. A load is also a resync: it seeds the accumulator with PHASE, which offsets the output phase in steps of 360/MOD degrees. When no offset is wanted, PHASE is normally written as 1. Each load is range-checked. A rejected load leaves every setting and the accumulator as they were, and sets a sticky error flag. The dither enable selects a low-spur mode. In that mode a 15-bit maximal-length pseudo-random bit is added to the accumulator input, so the carry pattern is whitened while the accumulator stays bounded by MOD. With dither disabled (low-noise mode) the sequence is exactly periodic.

Top module: `frac_ratio_seq`

## Requirements
- R1: After reset, div_val, carry, acc and cfg_err are all 0. The held settings are INT=23, FRAC=0, MOD=2, prescaler 4/5 and dither off.
- R2: A load that passes the checks makes acc equal PHASE and carry 0 in the following cycle. The new INT, FRAC, MOD and dither settings are used from the next enabled step on. A load with unchanged words therefore acts as a phase resync.
- R3: On an enabled step (step_en=1, no load) with dither off, the next acc is (acc+FRAC) mod MOD. carry is 1 exactly when the sum reached MOD. div_val becomes INT+carry. All three are registered and change one cycle after the step.
- R4: With dither off, the number of carries over any MOD consecutive enabled steps equals FRAC. This holds for any starting phase, including right after a resync.
- R5: The minimum legal INT is 23 when presc_sel=0 (4/5 mode) and 75 when presc_sel=1 (8/9 mode). A load with INT below the minimum for its own presc_sel is rejected.
- R6: A load is rejected when FRAC >= MOD, when PHASE >= MOD, or when MOD < 2.
- R7: A rejected load sets cfg_err, which stays 1 until reset. The held settings and acc are unchanged by it.
- R8: In a cycle with step_en=0 and no load, acc and div_val hold their values and carry is 0.
- R9: With dither on (low-spur mode), each enabled step advances acc by FRAC or FRAC+1 modulo MOD, and acc stays below MOD. carry marks a wrap, div_val is INT+carry, and over a long run both increments occur.
- R10: A load has priority over step_en in the same cycle. Its outcome is the same as a load with step_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the accumulator this cycle |
| load | input | 1 | Load/resync strobe: check and take the programmed words, seed acc with PHASE |
| int_word | input | 16 | Integer part of the division ratio |
| frac_word | input | 12 | Fractional numerator |
| mod_word | input | 12 | Fractional modulus |
| phase_word | input | 12 | Accumulator seed (phase offset) |
| presc_sel | input | 1 | 0 selects 4/5 prescaler mode, 1 selects 8/9 |
| dither_en | input | 1 | 1 selects low-spur mode with dither, 0 selects low-noise mode |
| div_val | output | 17 | Division value for the cycle (INT or INT+1) |
| carry | output | 1 | Accumulator wrapped on the last step |
| acc | output | 12 | Fractional accumulator contents |
| cfg_err | output | 1 | Sticky flag for a rejected load |

## Verification
Every cycle, the assertions check that the accumulator stays below the held modulus and that held FRAC stays below MOD. They also check that INT respects the floor of the held prescaler mode, that idle cycles change nothing, and that a dither-free step wraps exactly when the accumulator falls. They further check that a rejected load freezes the settings, that the error flag is sticky, and that the dither register never reaches the all-zero state. Only the bench scenarios can show properties that span many cycles. These are the carry count over a full MOD window (including after resyncs), the presence of both increments in dither mode, and the exact boundary values of the INT floor in each mode.

// File: rtl/frs_pkg.sv
// Shared constants and types for the fractional-N ratio sequencer.
package frs_pkg;
    // Smallest legal integer word for each prescaler mode
    localparam int MIN_INT_LOW_PRESC  = 23;
    localparam int MIN_INT_HIGH_PRESC = 75;

    // Prescaler mode encoding on presc_sel
    typedef enum logic {
        PRESC_4_5 = 1'b0,
        PRESC_8_9 = 1'b1
    } presc_e;
endpackage

// File: rtl/frs_cfg_guard.sv
// Configuration guard: range-checks the programmed words on a load strobe,
// holds the last accepted set and raises a sticky error on a rejected load.
// Assumes load is a single-cycle strobe; inputs are only sampled on load.
module frs_cfg_guard
    import frs_pkg::*;
#(
    parameter int INT_W    = 16,
    parameter int FW       = 12,
    parameter int DEF_INT  = 23,
    parameter int DEF_FRAC = 0,
    parameter int DEF_MOD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [FW-1:0]    frac_i,
    input  logic [FW-1:0]    mod_i,
    input  logic [FW-1:0]    phase_i,
    input  presc_e           presc_i,
    input  logic             dith_i,
    output logic [INT_W-1:0] int_o,
    output logic [FW-1:0]    frac_o,
    output logic [FW-1:0]    mod_o,
    output logic             dith_o,
    output logic             seed_o,
    output logic             cfg_err_o
);
    localparam logic [INT_W-1:0] FLOOR_LO = INT_W'(MIN_INT_LOW_PRESC);
    localparam logic [INT_W-1:0] FLOOR_HI = INT_W'(MIN_INT_HIGH_PRESC);
    localparam logic [FW-1:0]    MOD_MIN  = FW'(2);

    presc_e           presc_q;
    logic [INT_W-1:0] floor_int;
    logic             words_ok;

    // Legality of the words presented with the strobe
    always_comb begin
        floor_int = (presc_i == PRESC_8_9) ? FLOOR_HI : FLOOR_LO;
        words_ok  = (int_i >= floor_int) && (frac_i < mod_i) &&
                    (phase_i < mod_i) && (mod_i >= MOD_MIN);
    end

    assign seed_o = load_i && words_ok;

    // Held settings: replaced only by an accepted load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_o   <= INT_W'(DEF_INT);
            frac_o  <= FW'(DEF_FRAC);
            mod_o   <= FW'(DEF_MOD);
            presc_q <= PRESC_4_5;
            dith_o  <= 1'b0;
        end else if (seed_o) begin
            int_o   <= int_i;
            frac_o  <= frac_i;
            mod_o   <= mod_i;
            presc_q <= presc_i;
            dith_o  <= dith_i;
        end
    end

    // Sticky error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err_o <= 1'b0;
        else if (load_i && !words_ok)
            cfg_err_o <= 1'b1;
    end

    // R7: a rejected load leaves every held setting untouched and flags it
    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !words_ok) |=> ($stable(int_o) && $stable(frac_o) &&
                                   $stable(mod_o) && $stable(dith_o) && cfg_err_o));

    // R7: the error flag never drops while out of reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);

    // R5: held integer respects the floor of the held prescaler mode
    p_int_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_o >= ((presc_q == PRESC_8_9) ? FLOOR_HI : FLOOR_LO));

    // R6: held fraction below held modulus, modulus at least two
    p_frac_below_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_o < mod_o) && (mod_o >= MOD_MIN));
endmodule

// File: rtl/frs_dither_lfsr.sv
// Pseudo-random bit source: Fibonacci shift register, advanced on demand.
// Assumes TAP_MASK describes a maximal-length polynomial for width W;
// the default is x^15 + x^14 + 1.
module frs_dither_lfsr #(
    parameter int           W        = 15,
    parameter logic [W-1:0] TAP_MASK = 15'h6000,
    parameter logic [W-1:0] SEED     = 15'h0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic bit_o
);
    logic [W-1:0] state_q;
    logic         fb;

    // Feedback is the parity of the tapped stages
    always_comb fb = ^(state_q & TAP_MASK);

    // Shift one place per advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (adv_i)
            state_q <= {state_q[W-2:0], fb};
    end

    assign bit_o = state_q[W-1];

    // R9: a lock-up state would freeze the dither; never reachable
    p_lfsr_alive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/frs_accum.sv
// Fractional accumulator: adds the fraction (plus an optional dither bit)
// modulo MOD on each step, reports the wrap as carry and forms INT+carry.
// Assumes acc < mod and frac < mod on entry (kept by the configuration guard),
// so a single conditional subtraction suffices even with the dither bit.
module frs_accum #(
    parameter int INT_W = 16,
    parameter int FW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_i,
    input  logic [FW-1:0]    seed_val_i,
    input  logic             step_i,
    input  logic             dith_bit_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [FW-1:0]    frac_i,
    input  logic [FW-1:0]    mod_i,
    output logic [FW-1:0]    acc_o,
    output logic             carry_o,
    output logic [INT_W:0]   div_o
);
    logic [FW:0]   sum;
    logic          wrap;
    logic [FW-1:0] acc_nxt;

    // Next accumulator value and wrap detection
    always_comb begin
        sum     = {1'b0, acc_o} + {1'b0, frac_i} + {{FW{1'b0}}, dith_bit_i};
        wrap    = (sum >= {1'b0, mod_i});
        acc_nxt = wrap ? FW'(sum - {1'b0, mod_i}) : sum[FW-1:0];
    end

    // Seed has priority over a step; idle cycles hold acc and div
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o   <= '0;
            carry_o <= 1'b0;
            div_o   <= '0;
        end else if (seed_i) begin
            acc_o   <= seed_val_i;
            carry_o <= 1'b0;
        end else if (step_i) begin
            acc_o   <= acc_nxt;
            carry_o <= wrap;
            div_o   <= {1'b0, int_i} + {{INT_W{1'b0}}, wrap};
        end else begin
            carry_o <= 1'b0;
        end
    end

    // R3/R9: accumulator never reaches the held modulus
    p_acc_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o < mod_i);

    // R2/R10: an accepted load seeds the accumulator regardless of step
    p_seed_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed_i |=> (acc_o == $past(seed_val_i)) && !carry_o);

    // R8: idle cycle holds state and clears the carry
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_i && !step_i) |=> ($stable(acc_o) && $stable(div_o) && !carry_o));

    // R3: without dither, a wrap is exactly a drop of the accumulator
    p_carry_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !seed_i && !dith_bit_i) |=> (carry_o == (acc_o < $past(acc_o))));
endmodule

// File: rtl/frac_ratio_seq.sv
// Fractional-N divider ratio sequencer top level. Combines the configuration
// guard, the dither source and the fractional accumulator. Assumes one step
// per enabled reference cycle and a single-cycle load strobe.
module frac_ratio_seq
    import frs_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FW     = 12,
    parameter int LFSR_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             load,
    input  logic [INT_W-1:0] int_word,
    input  logic [FW-1:0]    frac_word,
    input  logic [FW-1:0]    mod_word,
    input  logic [FW-1:0]    phase_word,
    input  logic             presc_sel,
    input  logic             dither_en,
    output logic [INT_W:0]   div_val,
    output logic             carry,
    output logic [FW-1:0]    acc,
    output logic             cfg_err
);
    logic [INT_W-1:0] int_q;
    logic [FW-1:0]    frac_q;
    logic [FW-1:0]    mod_q;
    logic             dith_q;
    logic             seed;
    logic             lfsr_bit;
    logic             dith_bit;
    logic             step;

    frs_cfg_guard #(.INT_W(INT_W), .FW(FW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .int_i     (int_word),
        .frac_i    (frac_word),
        .mod_i     (mod_word),
        .phase_i   (phase_word),
        .presc_i   (presc_e'(presc_sel)),
        .dith_i    (dither_en),
        .int_o     (int_q),
        .frac_o    (frac_q),
        .mod_o     (mod_q),
        .dith_o    (dith_q),
        .seed_o    (seed),
        .cfg_err_o (cfg_err)
    );

    // A step happens only when no load claims the cycle
    always_comb begin
        step     = step_en && !load;
        dith_bit = dith_q && lfsr_bit;
    end

    frs_dither_lfsr #(.W(LFSR_W)) u_dither (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (step && dith_q),
        .bit_o (lfsr_bit)
    );

    frs_accum #(.INT_W(INT_W), .FW(FW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_i     (seed),
        .seed_val_i (phase_word),
        .step_i     (step),
        .dith_bit_i (dith_bit),
        .int_i      (int_q),
        .frac_i     (frac_q),
        .mod_i      (mod_q),
        .acc_o      (acc),
        .carry_o    (carry),
        .div_o      (div_val)
    );
endmodule

// File: tb/frac_ratio_seq_test.sv
`timescale 1ns/1ps
module frac_ratio_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] int_word = '0;
    logic [11:0] frac_word = '0;
    logic [11:0] mod_word = '0;
    logic [11:0] phase_word = '0;
    logic        presc_sel = 1'b0;
    logic        dither_en = 1'b0;
    logic [16:0] div_val;
    logic        carry;
    logic [11:0] acc;
    logic        cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the held settings and state
    int m_int, m_frac, m_mod, m_acc, m_div, m_carry, m_err;

    always #2.5 clk = ~clk;

    frac_ratio_seq uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load(load),
        .int_word(int_word), .frac_word(frac_word), .mod_word(mod_word),
        .phase_word(phase_word), .presc_sel(presc_sel), .dither_en(dither_en),
        .div_val(div_val), .carry(carry), .acc(acc), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit legal(int i, int f, int m, int p, bit pre);
        int floor_v = pre ? 75 : 23;
        return (i >= floor_v) && (f < m) && (p < m) && (m >= 2);
    endfunction

    task automatic check_state(input string req);
        chk({req, " acc"}, 32'(acc), 32'(m_acc));
        chk({req, " carry"}, 32'(carry), 32'(m_carry));
        chk({req, " div_val"}, 32'(div_val), 32'(m_div));
        chk({req, " cfg_err"}, 32'(cfg_err), 32'(m_err));
    endtask

    // load strobe with optional concurrent step_en (R10), model update (R2/R7)
    task automatic do_load(int i, int f, int m, int p, bit pre, bit d, bit with_step, string req);
        int_word = 16'(i); frac_word = 12'(f); mod_word = 12'(m);
        phase_word = 12'(p); presc_sel = pre; dither_en = d;
        load = 1'b1; step_en = with_step;
        tick();
        load = 1'b0; step_en = 1'b0;
        if (legal(i, f, m, p, pre)) begin
            m_int = i; m_frac = f; m_mod = m; m_acc = p;
        end else begin
            m_err = 1;
        end
        m_carry = 0;
        check_state(req);
    endtask

    // one cycle, stepping or idle, checked against the dither-free model
    task automatic cyc(bit en, string req);
        int s;
        step_en = en;
        tick();
        step_en = 1'b0;
        if (en) begin
            s = m_acc + m_frac;
            m_carry = (s >= m_mod) ? 1 : 0;
            m_acc = m_carry ? s - m_mod : s;
            m_div = m_int + m_carry;
        end else begin
            m_carry = 0;
        end
        check_state(req);
    endtask

    // R4: carries over MOD enabled steps, with random idle gaps (R8)
    task automatic window(bit gaps, string req);
        int cnt = 0;
        int taken = 0;
        while (taken < m_mod) begin
            if (gaps && ($urandom % 5 == 0)) cyc(1'b0, "R8 idle gap");
            else begin
                cyc(1'b1, "R3 step");
                cnt += carry;
                taken++;
            end
        end
        chk(req, 32'(cnt), 32'(m_frac));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a, b, dl, exp_c, plus1, plus0, m, f, p, i;
        bit pre;
        void'($urandom(32'd4242));
        m_int = 23; m_frac = 0; m_mod = 2; m_acc = 0; m_div = 0; m_carry = 0; m_err = 0;
        tick(); tick();
        check_state("R1 reset");
        rst_n = 1'b1;
        tick();
        // R1: default settings step with FRAC=0, MOD=2, INT=23
        cyc(1'b1, "R1 default step");

        // R2: directed load then R3/R4 stepping
        do_load(100, 5, 13, 1, 1'b0, 1'b0, 1'b0, "R2 load");
        window(1'b0, "R4 carries 5/13");
        cyc(1'b0, "R8 hold");

        // R5: exact floor boundaries in both prescaler modes (legal)
        do_load(23, 2, 7, 6, 1'b0, 1'b0, 1'b0, "R5 int 23 low mode");
        window(1'b0, "R4 carries 2/7");
        do_load(75, 0, 2, 1, 1'b1, 1'b0, 1'b0, "R5 int 75 high mode");
        window(1'b0, "R4 carries 0/2");
        do_load(65535, 4094, 4095, 4094, 1'b1, 1'b0, 1'b0, "R5 int max");
        for (int k = 0; k < 5; k++) cyc(1'b1, "R3 near-full fraction");

        // R10: load with step_en high seeds, does not step
        do_load(200, 3, 10, 9, 1'b0, 1'b0, 1'b1, "R10 load beats step");
        window(1'b0, "R4 carries 3/10");

        // random configurations with resyncs and gaps
        for (int it = 0; it < 24; it++) begin
            m = 2 + ($urandom % 300);
            f = $urandom % m;
            p = $urandom % m;
            pre = 1'($urandom % 2);
            i = (pre ? 75 : 23) + ($urandom % (65536 - (pre ? 75 : 23)));
            do_load(i, f, m, p, pre, 1'b0, 1'($urandom % 2), "R2 random load");
            for (int k = 0; k < int'($urandom % 20); k++) cyc(1'($urandom % 2), "R3 random");
            // resync with same words and a new phase
            do_load(i, f, m, $urandom % m, pre, 1'b0, 1'b0, "R2 resync");
            window(1'b1, "R4 carries after resync");
        end

        // R9: dither mode
        do_load(500, 10, 37, 3, 1'b0, 1'b1, 1'b0, "R9 dither load");
        plus1 = 0; plus0 = 0;
        for (int k = 0; k < 400; k++) begin
            a = acc;
            step_en = 1'b1;
            tick();
            step_en = 1'b0;
            b = acc;
            chk("R9 acc below MOD", 32'(b < 37), 32'd1);
            dl = (b + 37 - a) % 37;
            chk("R9 increment FRAC or FRAC+1", 32'((dl == 10) || (dl == 11)), 32'd1);
            exp_c = (a + dl >= 37) ? 1 : 0;
            chk("R9 carry", 32'(carry), 32'(exp_c));
            chk("R9 div_val", 32'(div_val), 32'(500 + exp_c));
            if (dl == 11) plus1++; else plus0++;
        end
        chk("R9 both increments seen", 32'((plus1 > 0) && (plus0 > 0)), 32'd1);
        m_acc = acc; m_carry = 0; m_div = div_val; m_int = 500; m_frac = 10; m_mod = 37;
        cyc(1'b0, "R8 hold after dither");
        // back to low-noise mode: exact periodicity returns
        do_load(500, 10, 37, 0, 1'b0, 1'b0, 1'b0, "R2 dither off");
        window(1'b0, "R4 carries 10/37");

        // R5/R6/R7: rejected loads (settings and acc kept, flag sticky)
        do_load(74, 1, 5, 1, 1'b1, 1'b0, 1'b0, "R5 int 74 high mode rejected");
        do_load(22, 1, 5, 1, 1'b0, 1'b0, 1'b0, "R5 int 22 low mode rejected");
        do_load(300, 8, 8, 1, 1'b0, 1'b0, 1'b0, "R6 FRAC=MOD rejected");
        do_load(300, 1, 8, 8, 1'b0, 1'b0, 1'b0, "R6 PHASE=MOD rejected");
        do_load(300, 0, 1, 0, 1'b0, 1'b0, 1'b0, "R6 MOD=1 rejected");
        window(1'b0, "R7 old settings still in force");
        // legal load still accepted while flag stays set
        do_load(80, 1, 4, 2, 1'b1, 1'b0, 1'b0, "R7 flag sticky on legal load");
        window(1'b0, "R4 carries 1/4");

        // R1: reset clears the flag and the state
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        m_int = 23; m_frac = 0; m_mod = 2; m_acc = 0; m_div = 0; m_carry = 0; m_err = 0;
        check_state("R1 reset clears");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule